// File: doc/BRIEF.md
# Serialized 16-bit Block Encryption Engine

This block encrypts one 64-bit block under an 80-bit key with a lightweight
substitution-permutation cipher of 25 rounds. Every register and every
operation works on 16-bit slices, so one round takes four clocks. The block
stores the state as four 16-bit rows and the key as five 16-bit rows. Each
clock, four data S-boxes handle one 4-column slice of the state. Four more
S-boxes serve the key update. The row rotations take no separate network:
the rows reload in parallel with their rotated value on the last slice of
each round.

Words enter on a valid/ready input stream that carries a plaintext word and
a key word side by side. The result leaves on a valid/ready output stream as
four 16-bit words. A word is transferred on a clock edge where valid and
ready are both high. The producer may hold valid low between words. The
consumer may hold ready low for any number of cycles, and the block then
keeps the current ciphertext word steady. From the fifth input beat until
the last output word is taken, the block accepts no input.

Top module: `enc16_serial`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A block takes five input beats. Beats 1 to 4 carry the plaintext rows, most significant first (bits 63:48 first), together with key bits 79:64, 63:48, 47:32 and 31:16. Beat 5 carries key bits 15:0, and its in_text value has no effect on the result.
- R3: Only beats with in_valid and in_ready both high count, and idle gaps between beats are allowed. in_ready stays 0 from the fifth accepted beat until the fourth output word is taken, and in_ready and out_valid are never high together.
- R4: Number the state rows 0 to 3, where row 0 is bits 15:0 and row 3 is bits 63:48. A column's 4-bit value has row 0 as its LSB. Each of the 25 rounds XORs the round key's low 64 bits into the state. It then replaces each column c with S[c], where S = 6,5,C,A,1,E,7,9,B,0,3,D,8,F,4,2 for inputs 0 to F. Last, it rotates rows 0 to 3 left by 0, 1, 12 and 13 bits. After round 25 the state is XORed with the low 64 bits of the 26th round key.
- R5: The key has rows 0 to 4, where row 0 is bits 15:0. After each round the key is updated in three steps. First, S replaces columns 0 to 3 of rows 0 to 3. Second, with rows a to e meaning rows 0 to 4 at this point, the new rows are: row 0 = (a rotated left 8) XOR b; row 1 = c; row 2 = d; row 3 = (d rotated left 12) XOR e; row 4 = a. Third, a 5-bit constant is XORed into bits 4:0 of row 0. The constant starts at 1 and steps as (c4..c0) -> (c3,c2,c1,c0,c4^c2).
- R6: out_valid rises exactly 100 clock edges after the edge that accepts the fifth input beat.
- R7: The ciphertext leaves as four words, bits 63:48 first and bits 15:0 last.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_text holds its value.
- R9: On the cycle after the fourth output word is taken, in_ready is 1, and a new block may follow at once with no effect from the previous one.
- R10: in_valid pulses while the block is busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts an input beat |
| in_text | input | 16 | Plaintext word of the beat |
| in_key | input | 16 | Key word of the beat |
| out_valid | output | 1 | Ciphertext word offered |
| out_ready | input | 1 | Consumer takes the ciphertext word |
| out_text | output | 16 | Ciphertext word |

## Verification
The fifth input beat is accepted on an edge. The bench then counts rising
edges and samples out_valid at each falling edge. It expects 0 through edge
99 and 1 exactly after edge 100. Each output word is read at the falling edge
before the edge that takes it. During a stall, the word is sampled again one
full cycle later to confirm it is unchanged. in_ready is checked at the
falling edge right after the fourth word is taken. Expected ciphertexts come
from a whole-block reference computation in the bench, which follows R4 and
R5 one round at a time.

// File: rtl/enc16_pkg.sv
`timescale 1ns/1ps
package enc16_pkg;
  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;
  localparam int D_ROWS = 4;
  localparam int K_ROWS = 5;
  localparam int SLICES = WORD_W / NIB_W;
  localparam int SL_W   = $clog2(SLICES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_KEYW, ST_RUN, ST_DRAIN
  } seq_state_t;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'h6;  4'h1: y = 4'h5;  4'h2: y = 4'hC;  4'h3: y = 4'hA;
      4'h4: y = 4'h1;  4'h5: y = 4'hE;  4'h6: y = 4'h7;  4'h7: y = 4'h9;
      4'h8: y = 4'hB;  4'h9: y = 4'h0;  4'hA: y = 4'h3;  4'hB: y = 4'hD;
      4'hC: y = 4'h8;  4'hD: y = 4'hF;  4'hE: y = 4'h4;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [WORD_W-1:0] rotl16(input logic [WORD_W-1:0] v,
                                               input int unsigned n);
    return WORD_W'((v << n) | (v >> (WORD_W - n)));
  endfunction

  function automatic int unsigned row_rot(input int r);
    case (r)
      0:       return 0;
      1:       return 1;
      2:       return 12;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/enc16_ctrl.sv
`timescale 1ns/1ps
module enc16_ctrl
  import enc16_pkg::*;
#(
  parameter int ROUNDS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic out_ready,
  output logic out_valid,
  output logic take_text,
  output logic take_key,
  output logic key_last,
  output logic run_en,
  output logic slice_last,
  output logic drain_step
);
  localparam int RUN_CYC = ROUNDS * SLICES;
  localparam int CNT_W   = $clog2(RUN_CYC);

  seq_state_t state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic beat;

  assign in_ready   = (state == ST_IDLE) || (state == ST_LOAD) || (state == ST_KEYW);
  assign beat       = in_valid && in_ready;
  assign take_key   = beat;
  assign take_text  = beat && (state != ST_KEYW);
  assign key_last   = beat && (state == ST_KEYW);
  assign run_en     = (state == ST_RUN);
  assign slice_last = run_en && (cnt[SL_W-1:0] == '1);
  assign out_valid  = (state == ST_DRAIN);
  assign drain_step = out_valid && out_ready;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    case (state)
      ST_IDLE: if (beat) begin
        state_nx = ST_LOAD;
        cnt_nx   = CNT_W'(1);
      end
      ST_LOAD: if (beat) begin
        if (cnt == CNT_W'(SLICES - 1)) begin
          state_nx = ST_KEYW;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      ST_KEYW: if (beat) begin
        state_nx = ST_RUN;
        cnt_nx   = '0;
      end
      ST_RUN: begin
        if (cnt == CNT_W'(RUN_CYC - 1)) begin
          state_nx = ST_DRAIN;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
      default: if (drain_step) begin
        if (cnt == CNT_W'(D_ROWS - 1)) begin
          state_nx = ST_IDLE;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (cnt < CNT_W'(RUN_CYC)));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_free_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_step && cnt == CNT_W'(D_ROWS - 1)) |=> in_ready);
endmodule

// File: rtl/enc16_data.sv
`timescale 1ns/1ps
module enc16_data
  import enc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_in,
  input  logic [WORD_W-1:0] in_word,
  input  logic              run_en,
  input  logic              slice_last,
  input  logic              drain_step,
  input  logic [WORD_W-1:0] key_top,
  output logic [WORD_W-1:0] top_word
);
  logic [WORD_W-1:0] drow     [D_ROWS];
  logic [WORD_W-1:0] shifted  [D_ROWS];
  logic [WORD_W-1:0] permuted [D_ROWS];
  logic [WORD_W-1:0] nib_flat;

  for (genvar b = 0; b < NIB_W; b++) begin : g_col
    logic [3:0] col_in, col_out;
    assign col_in = {drow[3][WORD_W-NIB_W+b], drow[2][WORD_W-NIB_W+b],
                     drow[1][WORD_W-NIB_W+b], drow[0][WORD_W-NIB_W+b]}
                  ^ {key_top[3*NIB_W+b], key_top[2*NIB_W+b],
                     key_top[NIB_W+b], key_top[b]};
    assign col_out = sbox4(col_in);
    for (genvar r = 0; r < D_ROWS; r++) begin : g_bit
      assign nib_flat[NIB_W*r+b] = col_out[r];
    end
  end

  for (genvar r = 0; r < D_ROWS; r++) begin : g_row
    assign shifted[r]  = {drow[r][WORD_W-NIB_W-1:0], nib_flat[NIB_W*r +: NIB_W]};
    assign permuted[r] = rotl16(shifted[r], row_rot(r));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < D_ROWS; r++) drow[r] <= '0;
    end else if (shift_in) begin
      for (int r = D_ROWS - 1; r > 0; r--) drow[r] <= drow[r-1];
      drow[0] <= in_word;
    end else if (run_en) begin
      for (int r = 0; r < D_ROWS; r++) drow[r] <= slice_last ? permuted[r] : shifted[r];
    end else if (drain_step) begin
      for (int r = D_ROWS - 1; r > 0; r--) drow[r] <= drow[r-1];
      drow[0] <= '0;
    end
  end

  assign top_word = drow[D_ROWS-1];
endmodule

// File: rtl/enc16_key.sv
`timescale 1ns/1ps
module enc16_key
  import enc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_in,
  input  logic [WORD_W-1:0] in_word,
  input  logic              key_last,
  input  logic              run_en,
  input  logic              slice_last,
  input  logic              drain_step,
  output logic [WORD_W-1:0] key_top,
  output logic [WORD_W-1:0] key_hi
);
  localparam logic [4:0] RC_SEED = 5'h01;

  logic [WORD_W-1:0] krow   [K_ROWS];
  logic [WORD_W-1:0] rot    [D_ROWS];
  logic [WORD_W-1:0] subbed [D_ROWS];
  logic [WORD_W-1:0] upd    [K_ROWS];
  logic [WORD_W-1:0] ks_flat;
  logic [4:0] rc;

  for (genvar r = 0; r < D_ROWS; r++) begin : g_rot
    assign rot[r] = {krow[r][WORD_W-NIB_W-1:0], krow[r][WORD_W-1:WORD_W-NIB_W]};
  end

  for (genvar b = 0; b < NIB_W; b++) begin : g_col
    logic [3:0] col_out;
    assign col_out = sbox4({rot[3][b], rot[2][b], rot[1][b], rot[0][b]});
    for (genvar r = 0; r < D_ROWS; r++) begin : g_bit
      assign ks_flat[NIB_W*r+b] = col_out[r];
    end
  end

  for (genvar r = 0; r < D_ROWS; r++) begin : g_sub
    assign subbed[r] = {rot[r][WORD_W-1:NIB_W], ks_flat[NIB_W*r +: NIB_W]};
  end

  assign upd[0] = rotl16(subbed[0], 8) ^ subbed[1] ^ {{(WORD_W-5){1'b0}}, rc};
  assign upd[1] = subbed[2];
  assign upd[2] = subbed[3];
  assign upd[3] = rotl16(subbed[3], 12) ^ krow[4];
  assign upd[4] = subbed[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < K_ROWS; r++) krow[r] <= '0;
      rc <= RC_SEED;
    end else if (shift_in) begin
      for (int r = K_ROWS - 1; r > 0; r--) krow[r] <= krow[r-1];
      krow[0] <= in_word;
      if (key_last) rc <= RC_SEED;
    end else if (run_en) begin
      if (slice_last) begin
        for (int r = 0; r < K_ROWS; r++) krow[r] <= upd[r];
        rc <= {rc[3:0], rc[4] ^ rc[2]};
      end else begin
        for (int r = 0; r < D_ROWS; r++) krow[r] <= rot[r];
      end
    end else if (drain_step) begin
      for (int r = D_ROWS - 1; r > 0; r--) krow[r] <= krow[r-1];
      krow[0] <= '0;
    end
  end

  assign key_top = {krow[3][WORD_W-1 -: NIB_W], krow[2][WORD_W-1 -: NIB_W],
                    krow[1][WORD_W-1 -: NIB_W], krow[0][WORD_W-1 -: NIB_W]};
  assign key_hi  = krow[D_ROWS-1];

  p_rc_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slice_last |=> (rc != 5'h00));
endmodule

// File: rtl/enc16_serial.sv
`timescale 1ns/1ps
module enc16_serial
  import enc16_pkg::*;
#(
  parameter int ROUNDS = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_text,
  input  logic [15:0] in_key,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_text
);
  logic take_text, take_key, key_last, run_en, slice_last, drain_step;
  logic [WORD_W-1:0] key_top, key_hi, dat_top;

  enc16_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .take_text(take_text),
    .take_key(take_key), .key_last(key_last), .run_en(run_en),
    .slice_last(slice_last), .drain_step(drain_step)
  );

  enc16_data u_data (
    .clk(clk), .rst_n(rst_n), .shift_in(take_text), .in_word(in_text),
    .run_en(run_en), .slice_last(slice_last), .drain_step(drain_step),
    .key_top(key_top), .top_word(dat_top)
  );

  enc16_key u_key (
    .clk(clk), .rst_n(rst_n), .shift_in(take_key), .in_word(in_key),
    .key_last(key_last), .run_en(run_en), .slice_last(slice_last),
    .drain_step(drain_step), .key_top(key_top), .key_hi(key_hi)
  );

  assign out_text = dat_top ^ key_hi;

  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_text)));
endmodule

// File: tb/test_enc16_serial.sv
`timescale 1ns/1ps
module test_enc16_serial;
  localparam real HALF = 2.5;
  localparam int  WDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_text = '0;
  logic [15:0] in_key = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [15:0] out_text;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  enc16_serial i_enc16_serial (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_text(in_text), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_text(out_text)
  );

  function automatic logic [3:0] ref_sub(input logic [3:0] x);
    logic [63:0] tbl = 64'h2_4_F_8_D_3_0_B_9_7_E_1_A_C_5_6;
    return tbl[4*x +: 4];
  endfunction

  function automatic logic [63:0] ref_encrypt(input logic [63:0] p, input logic [79:0] k);
    logic [15:0] s [4];
    logic [15:0] kk [5];
    logic [15:0] t [5];
    logic [4:0] rc;
    logic [3:0] c;
    for (int i = 0; i < 4; i++) s[i] = p[16*i +: 16];
    for (int i = 0; i < 5; i++) kk[i] = k[16*i +: 16];
    rc = 5'h01;
    for (int rnd = 0; rnd < 25; rnd++) begin
      for (int i = 0; i < 4; i++) s[i] = s[i] ^ kk[i];
      for (int j = 0; j < 16; j++) begin
        c = ref_sub({s[3][j], s[2][j], s[1][j], s[0][j]});
        for (int i = 0; i < 4; i++) s[i][j] = c[i];
      end
      s[1] = {s[1][14:0], s[1][15]};
      s[2] = {s[2][3:0], s[2][15:4]};
      s[3] = {s[3][2:0], s[3][15:3]};
      for (int j = 0; j < 4; j++) begin
        c = ref_sub({kk[3][j], kk[2][j], kk[1][j], kk[0][j]});
        for (int i = 0; i < 4; i++) kk[i][j] = c[i];
      end
      t[0] = {kk[0][7:0], kk[0][15:8]} ^ kk[1];
      t[1] = kk[2];
      t[2] = kk[3];
      t[3] = {kk[3][3:0], kk[3][15:4]} ^ kk[4];
      t[4] = kk[0];
      for (int i = 0; i < 5; i++) kk[i] = t[i];
      kk[0][4:0] = kk[0][4:0] ^ rc;
      rc = {rc[3:0], rc[4] ^ rc[2]};
    end
    return {s[3] ^ kk[3], s[2] ^ kk[2], s[1] ^ kk[1], s[0] ^ kk[0]};
  endfunction

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] t, input logic [15:0] k);
    @(negedge clk);
    in_valid = 1'b1;
    in_text  = t;
    in_key   = k;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_block(input logic [63:0] pt, input logic [79:0] key, input int gap,
                           input bit stall, input bit junk, input logic [15:0] fifth,
                           input string tag);
    logic [63:0] exp = ref_encrypt(pt, key);
    logic [63:0] got = '0;
    logic [15:0] held;
    int k = 0;
    for (int w = 0; w < 5; w++) begin
      push((w < 4) ? pt[63-16*w -: 16] : fifth, key[79-16*w -: 16]);
      if (gap > 0 && w < 4) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          chk(in_ready == 1'b1, {tag, " R3 ready during gap"}, 64'(in_ready), 64'd1);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (junk) begin
        in_valid = 1'b1;
        in_text  = 16'(k * 40503);
        in_key   = 16'(k * 9973);
      end
      if (k == 50)
        chk(in_ready == 1'b0, {tag, " R3 busy blocks input"}, 64'(in_ready), 64'd0);
    end while (!out_valid && k < 150);
    in_valid = 1'b0;
    chk(k == 100, {tag, " R6 latency"}, 64'(k), 64'd100);
    for (int w = 0; w < 4; w++) begin
      if (stall) begin
        out_ready = 1'b0;
        held = out_text;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid && out_text == held, {tag, " R8 stalled word held"},
            {47'd0, out_valid, out_text}, {47'd0, 1'b1, held});
      end
      out_ready = 1'b1;
      chk(out_valid == 1'b1, {tag, " R7 word offered"}, 64'(out_valid), 64'd1);
      got[63-16*w -: 16] = out_text;
      chk(out_text == exp[63-16*w -: 16], {tag, " R2 R4 R5 R7 R10 word"},
          64'(out_text), 64'(exp[63-16*w -: 16]));
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, {tag, " R9 free after drain"},
        {62'd0, in_ready, out_valid}, 64'd2);
    chk(got == exp, {tag, " R4 block"}, got, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state",
        {62'd0, in_ready, out_valid}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release",
        {62'd0, in_ready, out_valid}, 64'd2);
  endtask

  task automatic t_zero();
    run_block(64'h0, 80'h0, 0, 1'b0, 1'b0, 16'h0, "zero");
  endtask

  task automatic t_ones_gaps();
    run_block(64'hFFFF_FFFF_FFFF_FFFF, {80{1'b1}}, 2, 1'b0, 1'b0, 16'hFFFF, "ones");
  endtask

  task automatic t_stall();
    run_block(64'h0123_4567_89AB_CDEF, 80'h0123_4567_89AB_CDEF_0123, 0, 1'b1, 1'b0,
              16'h0, "stall");
  endtask

  task automatic t_junk();
    run_block(64'hFEDC_BA98_7654_3210, 80'hA5A5_0F0F_3C3C_9696_C3C3, 1, 1'b0, 1'b1,
              16'hDEAD, "junk");
  endtask

  task automatic t_back_to_back();
    run_block(64'h1111_2222_3333_4444, 80'h8000_0000_0000_0000_0001, 0, 1'b1, 1'b0,
              16'h5555, "b2b_a");
    run_block(64'h1111_2222_3333_4444, 80'h8000_0000_0000_0000_0001, 0, 1'b0, 1'b0,
              16'h0, "b2b_b");
  endtask

  initial begin
    t_reset();
    t_zero();
    t_ones_gaps();
    t_stall();
    t_junk();
    t_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(WDOG_CYC * 2 * HALF);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule